// File: doc/BRIEF.md
# Multi-channel hit timestamp assembler

This block forms one time word for each hit seen on four timing channels. A frame marker arrives every 512 ns and fixes the collision moment. After each marker, a coarse counter counts the 16 ns periods of the reference clock. A 4-bit phase value from the clock multiplier tells which nanosecond of the current period is running. Each channel carries a stretched pulse whose length is 200 times the sub-nanosecond interval being measured. The block counts that length on its fast clock.

When a channel pulse rises, the block captures the coarse count and the nanosecond phase and raises a one-cycle hit flag. While the pulse stays high, a width counter runs. When the pulse falls, the block assembles the entry and writes it to that channel's four-entry queue, and a one-cycle load strobe marks the commit. A readout port selects a channel and pops one entry per cycle while its request is held.

Top module: `hit_stamp_top`

## Requirements
- R1: After reset, `eventHit`, `loadStrobe`, `rdValid` and `overrun` are all zero, `rdData` is zero, and every bit of `chanEmpty` is one.
- R2: The coarse count clears to 0 on a cycle where `syncIn` is high. It otherwise advances by one, wrapping modulo 32, on each cycle where `periodTick` is high. An entry holds the value the count had in the cycle its pulse was first sampled high. Ticks that arrive while the pulse is high do not change it.
- R3: An entry holds the value of `nsPhase` sampled in the cycle its pulse was first seen high.
- R4: The width field equals the number of clock cycles in which the channel pulse was sampled high.
- R5: The width field saturates at 2047. Bit 20 of the entry (the overflow flag) is 1 exactly when the pulse was high for more than 2047 cycles.
- R6: `eventHit[i]` is high for one cycle, the cycle after the rise of pulse i is sampled. `loadStrobe[i]` is high for one cycle, the cycle after the fall is sampled.
- R7: Entries have the layout {overflow[20], coarse[19:15], phase[14:11], width[10:0]}. Each channel holds up to 4 entries and returns them oldest first.
- R8: A commit to a channel whose queue already holds 4 entries is discarded. It leaves the stored entries unchanged and sets that channel's `overrun` bit, which stays set until reset.
- R9: While `rdReq` is high and the channel `rdSel` is not empty, one entry is popped per cycle and shown on `rdData` with `rdValid` high in the following cycle. A request to an empty channel gives `rdValid` low.
- R10: The channels work independently. Overlapping pulses on different channels each produce their own correct entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast count clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Frame marker, clears the coarse count |
| periodTick | input | 1 | One-cycle mark at each 16 ns period boundary |
| nsPhase | input | 4 | Nanosecond tick within the current period |
| pulseIn | input | 4 | Stretched pulse, one per channel |
| rdReq | input | 1 | Readout request |
| rdSel | input | 2 | Channel selected for readout |
| eventHit | output | 4 | One-cycle hit flag per channel |
| loadStrobe | output | 4 | One-cycle commit strobe per channel |
| chanEmpty | output | 4 | Queue empty per channel |
| overrun | output | 4 | Sticky dropped-entry flag per channel |
| rdValid | output | 1 | Read data valid |
| rdData | output | 21 | Popped entry |

## Verification
The bench sends period ticks while a pulse is high. A design that latched the coarse count at the fall instead of the rise would then store a later period. Pulses of exactly 2047 and 2048 cycles bracket the saturation point. An off-by-one counter would either wrap to a small width or raise the overflow flag one cycle early. A fifth hit into a full queue checks that the stored entries still come out intact and in order, and that the overrun bit appears. The drain runs with the request held through the empty point, which exposes a design that pops an empty queue or repeats its last entry.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;
  localparam int CH_NUM     = 4;
  localparam int COARSE_W   = 5;
  localparam int NS_W       = 4;
  localparam int WID_W      = 11;
  localparam int FIFO_DEPTH = 4;
  localparam int ENTRY_W    = 1 + COARSE_W + NS_W + WID_W;
  localparam int SEL_W      = $clog2(CH_NUM);
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  typedef struct packed {
    logic [CH_NUM-1:0] rise;
    logic [CH_NUM-1:0] run;
    logic [CH_NUM-1:0] fall;
    logic [CH_NUM-1:0] pop;
  } stampCtrl_t;
endpackage

// File: rtl/hit_stamp_ctrl.sv
module hit_stamp_ctrl
  import hit_stamp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncIn,
  input  logic                periodTick,
  input  logic [CH_NUM-1:0]   pulseIn,
  input  logic                rdReq,
  input  logic [SEL_W-1:0]    rdSel,
  input  logic [CH_NUM-1:0]   chanEmpty,
  output stampCtrl_t          ctrl,
  output logic [COARSE_W-1:0] coarseCnt,
  output logic [CH_NUM-1:0]   eventHit,
  output logic [CH_NUM-1:0]   loadStrobe
);
  logic [CH_NUM-1:0] pulsePrev;

  always_comb begin
    ctrl.rise = pulseIn & ~pulsePrev;
    ctrl.run  = pulseIn & pulsePrev;
    ctrl.fall = ~pulseIn & pulsePrev;
    for (int i = 0; i < CH_NUM; i++)
      ctrl.pop[i] = rdReq && (rdSel == SEL_W'(i)) && !chanEmpty[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulsePrev  <= '0;
      coarseCnt  <= '0;
      eventHit   <= '0;
      loadStrobe <= '0;
    end else begin
      pulsePrev  <= pulseIn;
      eventHit   <= ctrl.rise;
      loadStrobe <= ctrl.fall;
      if (syncIn)
        coarseCnt <= '0;
      else if (periodTick)
        coarseCnt <= coarseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/hit_stamp_datapath.sv
module hit_stamp_datapath
  import hit_stamp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stampCtrl_t          ctrl,
  input  logic [COARSE_W-1:0] coarseCnt,
  input  logic [NS_W-1:0]     nsPhase,
  input  logic [SEL_W-1:0]    rdSel,
  output logic [CH_NUM-1:0]   chanEmpty,
  output logic [CH_NUM-1:0]   overrun,
  output logic                rdValid,
  output logic [ENTRY_W-1:0]  rdData
);
  logic [ENTRY_W-1:0] headWord [CH_NUM];

  for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
    logic [COARSE_W-1:0] capCoarse;
    logic [NS_W-1:0]     capNs;
    logic [WID_W-1:0]    widthCnt;
    logic                widthOvf;
    logic [ENTRY_W-1:0]  mem [FIFO_DEPTH];
    logic [PTR_W-1:0]    wrPtr, rdPtr;
    logic [CNT_W-1:0]    fillCnt;
    logic                isFull, doPush, doPop;

    assign isFull       = (fillCnt == CNT_W'(FIFO_DEPTH));
    assign doPush       = ctrl.fall[g] && !isFull;
    assign doPop        = ctrl.pop[g];
    assign chanEmpty[g] = (fillCnt == '0);
    assign headWord[g]  = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capCoarse <= '0;
        capNs     <= '0;
        widthCnt  <= '0;
        widthOvf  <= 1'b0;
      end else if (ctrl.rise[g]) begin
        capCoarse <= coarseCnt;
        capNs     <= nsPhase;
        widthCnt  <= WID_W'(1);
        widthOvf  <= 1'b0;
      end else if (ctrl.run[g]) begin
        if (widthCnt == {WID_W{1'b1}})
          widthOvf <= 1'b1;
        else
          widthCnt <= widthCnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr      <= '0;
        rdPtr      <= '0;
        fillCnt    <= '0;
        overrun[g] <= 1'b0;
        for (int k = 0; k < FIFO_DEPTH; k++) mem[k] <= '0;
      end else begin
        if (doPush) begin
          mem[wrPtr] <= {widthOvf, capCoarse, capNs, widthCnt};
          wrPtr      <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
        if (ctrl.fall[g] && isFull)
          overrun[g] <= 1'b1;
        if (doPop)
          rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        if (doPush && !doPop)
          fillCnt <= fillCnt + 1'b1;
        else if (doPop && !doPush)
          fillCnt <= fillCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= |ctrl.pop;
      if (|ctrl.pop)
        rdData <= headWord[rdSel];
    end
  end
endmodule

// File: rtl/hit_stamp_top.sv
module hit_stamp_top
  import hit_stamp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncIn,
  input  logic               periodTick,
  input  logic [NS_W-1:0]    nsPhase,
  input  logic [CH_NUM-1:0]  pulseIn,
  input  logic               rdReq,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [CH_NUM-1:0]  eventHit,
  output logic [CH_NUM-1:0]  loadStrobe,
  output logic [CH_NUM-1:0]  chanEmpty,
  output logic [CH_NUM-1:0]  overrun,
  output logic               rdValid,
  output logic [ENTRY_W-1:0] rdData
);
  stampCtrl_t          ctrl;
  logic [COARSE_W-1:0] coarseCnt;

  hit_stamp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .periodTick(periodTick),
    .pulseIn(pulseIn), .rdReq(rdReq), .rdSel(rdSel), .chanEmpty(chanEmpty),
    .ctrl(ctrl), .coarseCnt(coarseCnt), .eventHit(eventHit),
    .loadStrobe(loadStrobe)
  );

  hit_stamp_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .coarseCnt(coarseCnt),
    .nsPhase(nsPhase), .rdSel(rdSel), .chanEmpty(chanEmpty),
    .overrun(overrun), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/hit_stamp_chk.sv
module hit_stamp_chk
  import hit_stamp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CH_NUM-1:0] pulseIn,
  input logic              rdReq,
  input logic [CH_NUM-1:0] eventHit,
  input logic [CH_NUM-1:0] loadStrobe,
  input logic [CH_NUM-1:0] overrun,
  input logic              rdValid
);
  for (genvar g = 0; g < CH_NUM; g++) begin : g_chk
    AST_HIT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(pulseIn[g]) && $past(rstN)) |=> eventHit[g]); // R6
    AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(pulseIn[g]) && $past(rstN)) |=> loadStrobe[g]); // R6
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      loadStrobe[g] |=> !loadStrobe[g]); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      overrun[g] |=> overrun[g]); // R8
  end

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq)); // R9
endmodule

bind hit_stamp_top hit_stamp_chk u_chk (
  .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .rdReq(rdReq),
  .eventHit(eventHit), .loadStrobe(loadStrobe), .overrun(overrun),
  .rdValid(rdValid)
);

// File: tb/hit_stamp_top_tb.sv
`timescale 1ns/1ps
module hit_stamp_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b0;
  logic        periodTick = 1'b0;
  logic [3:0]  nsPhase = '0;
  logic [3:0]  pulseIn = '0;
  logic        rdReq = 1'b0;
  logic [1:0]  rdSel = '0;
  logic [3:0]  eventHit, loadStrobe, chanEmpty, overrun;
  logic        rdValid;
  logic [20:0] rdData;

  int checks = 0;
  int errors = 0;
  int expCoarse = 0;

  always #2 clk = ~clk;

  hit_stamp_top u_dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .periodTick(periodTick),
    .nsPhase(nsPhase), .pulseIn(pulseIn), .rdReq(rdReq), .rdSel(rdSel),
    .eventHit(eventHit), .loadStrobe(loadStrobe), .chanEmpty(chanEmpty),
    .overrun(overrun), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic logic [20:0] mkEntry(int ovf, int crs, int ns, int w);
    return {ovf[0], crs[4:0], ns[3:0], w[10:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doSync();
    @(negedge clk) syncIn = 1'b1;
    @(negedge clk) syncIn = 1'b0;
    expCoarse = 0;
  endtask

  task automatic doTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) periodTick = 1'b1;
      @(negedge clk) periodTick = 1'b0;
    end
    expCoarse = (expCoarse + n) % 32;
  endtask

  task automatic hit(int ch, int ns, int n, string req);
    @(negedge clk) begin pulseIn[ch] = 1'b1; nsPhase = 4'(ns); end
    @(negedge clk) chk({req, " hit flag"}, 32'(eventHit[ch]), 32'd1);
    for (int i = 1; i < n; i++) @(negedge clk);
    pulseIn[ch] = 1'b0;
    @(negedge clk) chk({req, " load strobe"}, 32'(loadStrobe[ch]), 32'd1);
  endtask

  task automatic readOne(int ch, logic [20:0] exp, string req);
    @(negedge clk) begin rdReq = 1'b1; rdSel = 2'(ch); end
    @(negedge clk) rdReq = 1'b0;
    chk({req, " valid"}, 32'(rdValid), 32'd1);
    chk({req, " data"}, 32'(rdData), 32'(exp));
  endtask

  task automatic testReset();
    chk("R1 hit", 32'(eventHit), 0);
    chk("R1 strobe", 32'(loadStrobe), 0);
    chk("R1 valid", 32'(rdValid), 0);
    chk("R1 data", 32'(rdData), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 empty", 32'(chanEmpty), 32'hF);
  endtask

  task automatic testBasic();
    int c;
    doSync();
    doTicks(3);
    c = expCoarse;
    hit(0, 9, 5, "R4");
    readOne(0, mkEntry(0, c, 9, 5), "R3");
    @(negedge clk) begin pulseIn[0] = 1'b1; nsPhase = 4'd2; end
    doTicks(2);
    pulseIn[0] = 1'b0;
    @(negedge clk) chk("R6 strobe", 32'(loadStrobe[0]), 1);
    @(negedge clk) chk("R6 strobe single", 32'(loadStrobe[0]), 0);
    readOne(0, mkEntry(0, c, 2, 4), "R2 capture at rise");
  endtask

  task automatic testWrap();
    doSync();
    doTicks(33);
    hit(1, 7, 3, "R2");
    readOne(1, mkEntry(0, 1, 7, 3), "R2 wrap");
  endtask

  task automatic testSaturate();
    int c = expCoarse;
    hit(2, 5, 2047, "R5");
    hit(2, 6, 2048, "R5");
    readOne(2, mkEntry(0, c, 5, 2047), "R5 max no overflow");
    readOne(2, mkEntry(1, c, 6, 2047), "R5 overflow");
  endtask

  task automatic testOverrun();
    int c = expCoarse;
    for (int k = 0; k < 4; k++) hit(3, k + 1, k + 2, "R7");
    chk("R8 no overrun yet", 32'(overrun[3]), 0);
    hit(3, 12, 9, "R8");
    chk("R8 overrun set", 32'(overrun[3]), 1);
    @(negedge clk) begin rdReq = 1'b1; rdSel = 2'd3; end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 burst valid", 32'(rdValid), 1);
      chk("R7 order", 32'(rdData), 32'(mkEntry(0, c, k + 1, k + 2)));
    end
    @(negedge clk) chk("R9 drained no valid", 32'(rdValid), 0);
    rdReq = 1'b0;
    chk("R9 empty", 32'(chanEmpty[3]), 1);
    chk("R8 sticky", 32'(overrun[3]), 1);
  endtask

  task automatic testConcurrent();
    int c;
    doSync();
    doTicks(4);
    c = expCoarse;
    @(negedge clk) begin pulseIn[0] = 1'b1; nsPhase = 4'd3; end
    @(negedge clk) begin pulseIn[1] = 1'b1; nsPhase = 4'd11; end
    repeat (5) @(negedge clk);
    pulseIn[1] = 1'b0;
    repeat (2) @(negedge clk);
    pulseIn[0] = 1'b0;
    @(negedge clk) chk("R10 strobe ch0", 32'(loadStrobe[0]), 1);
    readOne(1, mkEntry(0, c, 11, 5), "R10 ch1");
    readOne(0, mkEntry(0, c, 3, 8), "R10 ch0");
    chk("R10 overrun ch0", 32'(overrun[0]), 0);
  endtask

  task automatic testEmptyRead();
    @(negedge clk) begin rdReq = 1'b1; rdSel = 2'd2; end
    @(negedge clk) rdReq = 1'b0;
    chk("R9 empty request", 32'(rdValid), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testWrap();
    testSaturate();
    testOverrun();
    testConcurrent();
    testEmptyRead();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule